// File: doc/BRIEF.md
# Blind Periodic Configuration Scrubber

This controller keeps the configuration memory of a small programmable fabric correct by rewriting all of it, over and over, at a short fixed period. It never reads the stored configuration back and never compares it with anything. The golden configuration arrives on a wide parallel input, and that source is taken to be correct. On every period the whole configuration register is overwritten in one parallel capture, so an upset bit lasts no longer than one period.

Each scrub period runs three phases in a fixed order. First the active-low precharge strobe `nref_n` is held low. Then comes a settle window in which the golden word is allowed to arrive. Last, the configuration clock `cfg_clk` is held high, and its rising edge loads every bit of the register at the same instant. The length of each phase, and of an optional idle gap after it, is set in system-clock cycles by its own input. While `scrub_en` is high the periods follow one another with no dead cycles. The golden input has no handshake: the value present at the latch edge is simply taken. A one-cycle `scrub_done` pulse and a wrapping scrub counter mark every capture.

Top module: `blind_scrub_ctrl`

## Requirements
- R1: After reset, `cfg_q` is all zeros, `nref_n` is 1, `cfg_clk` is 0, `scrub_done` is 0 and `scrub_count` is 0.
- R2: In each period, `nref_n` is low for max(P,1) cycles. It is followed by max(S,1) cycles with both strobes inactive, and then `cfg_clk` is high for max(H,1) cycles. P, S and H are `prech_len`, `settle_len` and `strobe_len`, so a length of 0 counts as 1.
- R3: On the clock edge at which `cfg_clk` rises, every bit of `cfg_q` takes the value `golden_cfg` had in the cycle just before, all bits in the same cycle.
- R4: `cfg_q` changes at no other time. Changes on `golden_cfg` outside the capture edge have no effect on it.
- R5: While enabled, periods repeat with a period of max(P,1)+max(S,1)+max(H,1)+G cycles, where G is `gap_len`. During the G gap cycles both strobes are inactive, and G = 0 means no gap.
- R6: While `scrub_en` is low and no period is in progress, `nref_n` stays 1, `cfg_clk` stays 0, no done pulse occurs and `cfg_q` holds. If enable drops during a period, that period and its gap still complete.
- R7: From idle, the first cycle after the clock edge that samples `scrub_en` high already has `nref_n` low.
- R8: `scrub_done` is high for exactly one cycle per period: the first cycle in which `cfg_clk` is high.
- R9: `scrub_count` increments by one in the cycle where `scrub_done` is high, holds otherwise, and wraps from its maximum value to 0.
- R10: `nref_n` low and `cfg_clk` high never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scrub_en | input | 1 | Allows new scrub periods to start |
| prech_len | input | CNT_W | Precharge phase length in cycles (0 is taken as 1) |
| settle_len | input | CNT_W | Settle phase length in cycles (0 is taken as 1) |
| strobe_len | input | CNT_W | Configuration-clock high time in cycles (0 is taken as 1) |
| gap_len | input | CNT_W | Idle gap after each period in cycles (0 means none) |
| golden_cfg | input | CFG_W | Golden configuration word |
| cfg_q | output | CFG_W | Configuration register |
| nref_n | output | 1 | Precharge strobe, active low |
| cfg_clk | output | 1 | Configuration clock; its rising edge is the capture |
| scrub_done | output | 1 | One-cycle pulse per capture |
| scrub_count | output | CNT_CW | Wrapping count of completed captures |

## Verification
The bench sweeps every combination of small phase lengths, including the zero lengths that must count as one cycle and the zero gap where periods run back to back. A design that mishandled zero lengths would stretch or drop a phase and shift the period. Because the golden word changes on every cycle, any capture taken one cycle early or late shows up as a wrong value, and so does a register that follows its input between captures. Enable is dropped at a different point inside the period for each combination, which catches a controller that aborts mid-period or starts one extra period. The narrow capture counter wraps several times during the run, so an increment that skips the wrap or counts twice is seen.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_PRECH  = 3'd1,
    PH_SETTLE = 3'd2,
    PH_STROBE = 3'd3,
    PH_GAP    = 3'd4
  } phase_e;

  // Converts a phase length in cycles into the timer preload (length minus one, floor at zero).
  function automatic logic [31:0] preload(input logic [31:0] len);
    return (len == 32'd0) ? 32'd0 : len - 32'd1;
  endfunction
endpackage

// File: rtl/scrub_phase_timer.sv
module scrub_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign expire = (remain_q == '0);
endmodule

// File: rtl/scrub_seq_fsm.sv
module scrub_seq_fsm
  import scrub_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scrub_en,
  input  logic [CNT_W-1:0] prech_len,
  input  logic [CNT_W-1:0] settle_len,
  input  logic [CNT_W-1:0] strobe_len,
  input  logic [CNT_W-1:0] gap_len,
  input  logic             expire,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             capture,
  output logic             nref_n,
  output logic             cfg_clk,
  output logic             done
);
  phase_e state_q, state_d;
  logic   cap_d;

  function automatic logic [CNT_W-1:0] pre(input logic [CNT_W-1:0] len);
    logic [31:0] v;
    v = preload(32'(len));
    return v[CNT_W-1:0];
  endfunction

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    cap_d    = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (scrub_en) begin
          state_d  = PH_PRECH;
          load     = 1'b1;
          load_val = pre(prech_len);
        end
      end
      PH_PRECH: begin
        if (expire) begin
          state_d  = PH_SETTLE;
          load     = 1'b1;
          load_val = pre(settle_len);
        end
      end
      PH_SETTLE: begin
        if (expire) begin
          state_d  = PH_STROBE;
          load     = 1'b1;
          load_val = pre(strobe_len);
          cap_d    = 1'b1;
        end
      end
      PH_STROBE: begin
        if (expire) begin
          if (gap_len != '0) begin
            state_d  = PH_GAP;
            load     = 1'b1;
            load_val = pre(gap_len);
          end else if (scrub_en) begin
            state_d  = PH_PRECH;
            load     = 1'b1;
            load_val = pre(prech_len);
          end else begin
            state_d  = PH_IDLE;
          end
        end
      end
      PH_GAP: begin
        if (expire) begin
          if (scrub_en) begin
            state_d  = PH_PRECH;
            load     = 1'b1;
            load_val = pre(prech_len);
          end else begin
            state_d  = PH_IDLE;
          end
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  assign capture = cap_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      nref_n  <= 1'b1;
      cfg_clk <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      nref_n  <= (state_d != PH_PRECH);
      cfg_clk <= (state_d == PH_STROBE);
      done    <= cap_d;
    end
  end
endmodule

// File: rtl/scrub_cfg_latch.sv
module scrub_cfg_latch #(
  parameter int NUM_LUT    = 4,
  parameter int LUT_BITS   = 16,
  parameter int ROUTE_BITS = 32,
  localparam int LUT_SPAN  = NUM_LUT * LUT_BITS,
  localparam int CFG_W     = LUT_SPAN + ROUTE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [CFG_W-1:0] golden_cfg,
  output logic [CFG_W-1:0] cfg_q
);
  // One register slice per truth table, all sharing the same capture strobe.
  for (genvar g = 0; g < NUM_LUT; g++) begin : g_lut
    logic [LUT_BITS-1:0] tt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tt_q <= '0;
      else if (capture) tt_q <= golden_cfg[g*LUT_BITS +: LUT_BITS];
    end
    assign cfg_q[g*LUT_BITS +: LUT_BITS] = tt_q;
  end

  if (ROUTE_BITS > 0) begin : g_route
    logic [ROUTE_BITS-1:0] rt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rt_q <= '0;
      else if (capture) rt_q <= golden_cfg[LUT_SPAN +: ROUTE_BITS];
    end
    assign cfg_q[LUT_SPAN +: ROUTE_BITS] = rt_q;
  end
endmodule

// File: rtl/scrub_event_counter.sv
module scrub_event_counter #(
  parameter int CNT_CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bump,
  output logic [CNT_CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (bump) count <= count + 1'b1;
  end
endmodule

// File: rtl/blind_scrub_ctrl.sv
module blind_scrub_ctrl #(
  parameter int NUM_LUT    = 4,
  parameter int LUT_BITS   = 16,
  parameter int ROUTE_BITS = 32,
  parameter int CNT_W      = 8,
  parameter int CNT_CW     = 8,
  localparam int CFG_W     = NUM_LUT * LUT_BITS + ROUTE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scrub_en,
  input  logic [CNT_W-1:0]  prech_len,
  input  logic [CNT_W-1:0]  settle_len,
  input  logic [CNT_W-1:0]  strobe_len,
  input  logic [CNT_W-1:0]  gap_len,
  input  logic [CFG_W-1:0]  golden_cfg,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              nref_n,
  output logic              cfg_clk,
  output logic              scrub_done,
  output logic [CNT_CW-1:0] scrub_count
);
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expire;
  logic             capture;

  scrub_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_expire)
  );

  scrub_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scrub_en   (scrub_en),
    .prech_len  (prech_len),
    .settle_len (settle_len),
    .strobe_len (strobe_len),
    .gap_len    (gap_len),
    .expire     (tmr_expire),
    .load       (tmr_load),
    .load_val   (tmr_val),
    .capture    (capture),
    .nref_n     (nref_n),
    .cfg_clk    (cfg_clk),
    .done       (scrub_done)
  );

  scrub_cfg_latch #(
    .NUM_LUT    (NUM_LUT),
    .LUT_BITS   (LUT_BITS),
    .ROUTE_BITS (ROUTE_BITS)
  ) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture),
    .golden_cfg (golden_cfg),
    .cfg_q      (cfg_q)
  );

  scrub_event_counter #(.CNT_CW(CNT_CW)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (capture),
    .count (scrub_count)
  );
endmodule

// File: rtl/scrub_ctrl_checker.sv
module scrub_ctrl_checker #(
  parameter int CFG_W  = 96,
  parameter int CNT_CW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CFG_W-1:0]  golden_cfg,
  input logic [CFG_W-1:0]  cfg_q,
  input logic              nref_n,
  input logic              cfg_clk,
  input logic              scrub_done,
  input logic [CNT_CW-1:0] scrub_count
);
  p_capture_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> cfg_q == $past(golden_cfg));

  p_hold_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(cfg_clk) |-> $stable(cfg_q));

  p_settle_before_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> $past(nref_n));

  p_done_marks_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_done |-> $rose(cfg_clk));

  p_edge_gives_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> scrub_done);

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_done |-> scrub_count == CNT_CW'($past(scrub_count) + 1'b1));

  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !scrub_done |-> $stable(scrub_count));

  p_strobes_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nref_n && cfg_clk));
endmodule

bind blind_scrub_ctrl scrub_ctrl_checker #(.CFG_W(CFG_W), .CNT_CW(CNT_CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .golden_cfg  (golden_cfg),
  .cfg_q       (cfg_q),
  .nref_n      (nref_n),
  .cfg_clk     (cfg_clk),
  .scrub_done  (scrub_done),
  .scrub_count (scrub_count)
);

// File: tb/blind_scrub_ctrl_tb.sv
module blind_scrub_ctrl_tb;
  localparam int NUM_LUT    = 2;
  localparam int LUT_BITS   = 16;
  localparam int ROUTE_BITS = 8;
  localparam int CNT_W      = 4;
  localparam int CNT_CW     = 4;
  localparam int CFG_W      = NUM_LUT * LUT_BITS + ROUTE_BITS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              scrub_en = 1'b0;
  logic [CNT_W-1:0]  prech_len = '0, settle_len = '0, strobe_len = '0, gap_len = '0;
  logic [CFG_W-1:0]  golden_cfg = '0;
  logic [CFG_W-1:0]  cfg_q;
  logic              nref_n, cfg_clk, scrub_done;
  logic [CNT_CW-1:0] scrub_count;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  blind_scrub_ctrl #(
    .NUM_LUT(NUM_LUT), .LUT_BITS(LUT_BITS), .ROUTE_BITS(ROUTE_BITS),
    .CNT_W(CNT_W), .CNT_CW(CNT_CW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en),
    .prech_len(prech_len), .settle_len(settle_len), .strobe_len(strobe_len), .gap_len(gap_len),
    .golden_cfg(golden_cfg), .cfg_q(cfg_q), .nref_n(nref_n), .cfg_clk(cfg_clk),
    .scrub_done(scrub_done), .scrub_count(scrub_count)
  );

  function automatic logic [CFG_W-1:0] pat(input int k, input int salt);
    logic [63:0] x;
    x = (64'(k) * 64'h9E37_79B9_7F4A_7C15) ^ (64'(salt) * 64'h0000_0100_0000_01B3) ^ 64'h5A5A_0F0F_3C3C_A5A5;
    return x[CFG_W-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  logic [CFG_W-1:0]  exp_cfg = '0;
  logic [CNT_CW-1:0] exp_cnt = '0;

  task automatic check_idle(input string req);
    chk(nref_n == 1'b1, req, 64'(nref_n), 64'd1);
    chk(cfg_clk == 1'b0, req, 64'(cfg_clk), 64'd0);
    chk(scrub_done == 1'b0, req, 64'(scrub_done), 64'd0);
    chk(cfg_q == exp_cfg, req, 64'(cfg_q), 64'(exp_cfg));
    chk(scrub_count == exp_cnt, req, 64'(scrub_count), 64'(exp_cnt));
  endtask

  // One enabled run for a length combination; enable drops after cycle kd.
  task automatic run_combo(input int p, input int s, input int h, input int g, input int salt);
    int pe, se, he, t, kd, last_idx, kmax;
    pe = (p == 0) ? 1 : p;
    se = (s == 0) ? 1 : s;
    he = (h == 0) ? 1 : h;
    t  = pe + se + he + g;
    kd = 2 * t + 1 + (salt % t);
    last_idx = (kd - 1) / t;
    kmax = (last_idx + 1) * t + 4;
    @(negedge clk);
    prech_len  = CNT_W'(p);
    settle_len = CNT_W'(s);
    strobe_len = CNT_W'(h);
    gap_len    = CNT_W'(g);
    golden_cfg = pat(0, salt);
    scrub_en   = 1'b1;
    for (int k = 1; k <= kmax; k++) begin
      int m, idx;
      bit act, e_nref, e_clk, e_done;
      @(negedge clk);
      m   = (k - 1) % t;
      idx = (k - 1) / t;
      act = (idx <= last_idx);
      e_nref = !(act && m < pe);
      e_clk  = act && (m >= pe + se) && (m < pe + se + he);
      e_done = act && (m == pe + se);
      if (e_done) begin
        exp_cfg = pat(k - 1, salt);
        exp_cnt = exp_cnt + 1'b1;
      end
      // R2 R5 R7: precharge placement and period; R6: quiet after the stop
      chk(nref_n == e_nref, act ? "R2/R5/R7 nref_n" : "R6 nref_n", 64'(nref_n), 64'(e_nref));
      chk(cfg_clk == e_clk, act ? "R2/R5 cfg_clk" : "R6 cfg_clk", 64'(cfg_clk), 64'(e_clk));
      chk(scrub_done == e_done, "R8 scrub_done", 64'(scrub_done), 64'(e_done));
      chk(cfg_q == exp_cfg, e_done ? "R3 capture" : "R4 hold", 64'(cfg_q), 64'(exp_cfg));
      chk(scrub_count == exp_cnt, "R9 scrub_count", 64'(scrub_count), 64'(exp_cnt));
      chk(!(!nref_n && cfg_clk), "R10 strobes apart", {62'd0, nref_n, cfg_clk}, 64'd2);
      golden_cfg = pat(k, salt);
      if (k == kd) scrub_en = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held and right after release
    check_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after release");
    // R6: disabled controller ignores golden changes for several cycles
    for (int k = 0; k < 8; k++) begin
      golden_cfg = pat(k, 999);
      @(negedge clk);
      check_idle("R6 disabled");
    end
    begin
      int salt;
      salt = 0;
      for (int p = 0; p <= 3; p++)
        for (int s = 0; s <= 3; s++)
          for (int h = 0; h <= 3; h++)
            for (int g = 0; g <= 2; g++) begin
              run_combo(p, s, h, g, salt);
              salt++;
            end
    end
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule